// File: doc/BRIEF.md
# Shared-Bus Multicycle Fetch and NOT Execute Core

This block is a narrow slice of a 16-bit processor in which every transfer between state elements passes over one shared data bus. A state machine produces, for each clock cycle, the gate enables that pick the single source allowed onto the bus and the load enables that decide which registers capture it. Instruction fetch takes three cycles: the program counter goes to the memory address register, memory is read into the memory data register while the program counter advances, and the fetched word moves into the instruction register. The opcode is then examined combinationally, so the branch to the execute step adds no cycle.

One instruction is executed: a bitwise complement from a source register into a destination register of an eight-entry register file, with the N/Z/P condition codes taken from the bus value. Every other opcode is treated as a no-op that returns straight to fetch and touches neither registers nor condition codes. The instruction memory is an internal array that is filled through a load port while reset is held. A combinational read port lets the surrounding logic observe any register.

Top module: `busfetch_core`

## Requirements
- R1: While `rst_n` is low at a rising edge, PC becomes 16'h3000, IR becomes 0, `cc_q` becomes 3'b010 (Z), register n becomes n × 16'h1111, and the controller enters fetch cycle 1 (`fetch_start` = 1).
- R2: In every cycle at most one bit of `drv_q` is set; `drv_q[2]` is the PC gate, `drv_q[1]` the MDR gate, `drv_q[0]` the ALU gate.
- R3: In fetch cycle 1 `drv_q` = 3'b100 and `fetch_start` = 1, and MAR captures PC.
- R4: In fetch cycle 2 `drv_q` = 3'b000, memory at MAR is loaded into MDR, and PC is incremented, so that PC at the start of the k-th fetch (k from 0) is 16'h3000 + k.
- R5: In fetch cycle 3 `drv_q` = 3'b010 and IR captures MDR; IR then holds the fetched word until the next fetch cycle 3.
- R6: Decode takes no cycle: an instruction with opcode other than NOT takes exactly 3 cycles from one `fetch_start` to the next, and a NOT takes exactly 4.
- R7: NOT has opcode 4'b1001 in IR[15:12], destination in IR[11:9] and source in IR[8:6]; in its execute cycle `drv_q` = 3'b001 and the destination register receives the bitwise complement of the source register.
- R8: After a NOT, exactly one of `cc_q` = {N,Z,P} is set: N when result bit 15 is 1, Z when the result is 0, P otherwise.
- R9: Opcodes other than 4'b1001 leave every register and `cc_q` unchanged; condition codes are loaded only in the execute cycle of an opcode from the set that may update them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| prog_we | input | 1 | Memory load strobe, honoured only while `rst_n` is low |
| prog_addr | input | 8 | Memory load address |
| prog_data | input | 16 | Memory load word |
| rd_sel | input | 3 | Register index for the observation read port |
| rd_data | output | 16 | Contents of register `rd_sel` |
| pc_q | output | 16 | Program counter |
| ir_q | output | 16 | Instruction register |
| cc_q | output | 3 | Condition codes {N,Z,P} |
| drv_q | output | 3 | Active bus gate {PC, MDR, ALU} |
| fetch_start | output | 1 | High in fetch cycle 1 |

## Verification
The assertions assume the memory is filled before reset is released and is not written afterwards, and that the fetched words cover only the address range that was loaded; the stimulus loads the whole program under reset and stops at the fetch boundary after the last loaded word. They also assume reset lasts at least one edge so the state machine and register file start from known values. The stimulus sweeps complement operations over many destination/source pairs, including self-complement and chained results that reach zero, negative and positive values, interleaved with every other opcode value.

// File: rtl/busfetch_pkg.sv
// Shared types and constants for the shared-bus fetch core.
// Assumes a 16-bit datapath and 4-bit opcode in the top bits of the instruction.
package busfetch_pkg;

    localparam int WORD_W  = 16;
    localparam int REG_N   = 8;
    localparam int REG_W   = $clog2(REG_N);
    localparam logic [WORD_W-1:0] PC_RESET = 16'h3000;

    localparam logic [3:0] OP_ADD = 4'b0001;
    localparam logic [3:0] OP_AND = 4'b0101;
    localparam logic [3:0] OP_NOT = 4'b1001;
    localparam logic [3:0] OP_LD  = 4'b0010;
    localparam logic [3:0] OP_LDI = 4'b1010;
    localparam logic [3:0] OP_LDR = 4'b0110;
    localparam logic [3:0] OP_LEA = 4'b1110;

    typedef enum logic [1:0] {
        ST_FETCH_A = 2'd0,
        ST_FETCH_B = 2'd1,
        ST_FETCH_C = 2'd2,
        ST_EXEC_NOT = 2'd3
    } ctl_state_t;

    typedef enum logic [1:0] {
        ALU_ADD  = 2'b00,
        ALU_AND  = 2'b01,
        ALU_NOT  = 2'b10,
        ALU_PASS = 2'b11
    } alu_fn_t;

    typedef enum logic [1:0] {
        PCSEL_BUS = 2'b00,
        PCSEL_HOLD = 2'b01,
        PCSEL_INC = 2'b10
    } pc_sel_t;

    typedef struct packed {
        logic            gate_pc;
        logic            gate_mdr;
        logic            gate_alu;
        logic            ld_mar;
        logic            ld_mdr;
        logic            mdr_from_mem;
        logic            mem_en;
        logic            ld_ir;
        logic            ld_pc;
        pc_sel_t         pc_sel;
        logic            ld_reg;
        logic            ld_cc;
        alu_fn_t         alu_fn;
        logic [REG_W-1:0] dst;
        logic [REG_W-1:0] src1;
    } ctl_word_t;

    // Opcodes allowed to change the condition codes.
    function automatic logic op_sets_cc(input logic [3:0] op);
        return (op == OP_ADD) || (op == OP_AND) || (op == OP_NOT) ||
               (op == OP_LD)  || (op == OP_LDI) || (op == OP_LDR) ||
               (op == OP_LEA);
    endfunction

    // Reset value of register idx.
    function automatic logic [WORD_W-1:0] reg_seed(input int idx);
        return WORD_W'(idx * 16'h1111);
    endfunction

endpackage

// File: rtl/bf_regfile.sv
// Register file: REG_N words, one write port from the bus, three
// combinational read ports (two for the ALU, one for observation).
// Assumes synchronous active-low reset loads each entry with its seed.
module bf_regfile
    import busfetch_pkg::*;
#(
    parameter int N = REG_N,
    parameter int W = WORD_W,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr_a,
    input  logic [AW-1:0] raddr_b,
    input  logic [AW-1:0] raddr_o,
    output logic [W-1:0]  rdata_a,
    output logic [W-1:0]  rdata_b,
    output logic [W-1:0]  rdata_o
);

    logic [W-1:0] regs [N];

    for (genvar g = 0; g < N; g++) begin : g_reg
        // Reset to the seed, otherwise capture the bus when addressed.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs[g] <= reg_seed(g);
            end else if (we && (waddr == AW'(g))) begin
                regs[g] <= wdata;
            end
        end
    end

    // Combinational reads.
    always_comb begin
        rdata_a = regs[raddr_a];
        rdata_b = regs[raddr_b];
        rdata_o = regs[raddr_o];
    end

endmodule

// File: rtl/bf_alu.sv
// Minimal ALU: add, and, complement, pass. Second operand is either a
// register or a sign-extended immediate field of the instruction.
// Assumes the immediate sits in the low IMM_W bits, selected by ir[IMM_W].
module bf_alu
    import busfetch_pkg::*;
#(
    parameter int W = WORD_W,
    parameter int IMM_W = 5
) (
    input  alu_fn_t      fn,
    input  logic [W-1:0] ir,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b_reg,
    output logic [W-1:0] result
);

    logic [W-1:0] op_b;

    // Pick register or sign-extended immediate for the second operand.
    always_comb begin
        if (ir[IMM_W]) begin
            op_b = {{(W-IMM_W){ir[IMM_W-1]}}, ir[IMM_W-1:0]};
        end else begin
            op_b = op_b_reg;
        end
    end

    // Function select.
    always_comb begin
        unique case (fn)
            ALU_ADD:  result = op_a + op_b;
            ALU_AND:  result = op_a & op_b;
            ALU_NOT:  result = ~op_a;
            default:  result = op_a;
        endcase
    end

endmodule

// File: rtl/bf_mem.sv
// Word memory: array filled through a load port while reset is held,
// read combinationally when enabled (the read is captured by MDR).
// Assumes loading is complete before reset is released.
module bf_mem
    import busfetch_pkg::*;
#(
    parameter int AW = 8,
    parameter int W = WORD_W,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_we,
    input  logic [AW-1:0] load_addr,
    input  logic [W-1:0]  load_data,
    input  logic          en,
    input  logic [AW-1:0] addr,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] mem [DEPTH];

    // Program load, only under reset.
    always_ff @(posedge clk) begin
        if (!rst_n && load_we) begin
            mem[load_addr] <= load_data;
        end
    end

    // Enabled read.
    always_comb begin
        rdata = en ? mem[addr] : '0;
    end

endmodule

// File: rtl/bf_ctrl.sv
// Control state machine: three fetch cycles, a zero-cycle decode on the
// word entering IR, and one execute cycle for NOT. Produces one control
// word per cycle with at most one bus gate active.
// Assumes IR is loaded from MDR at the end of fetch cycle 3.
module bf_ctrl
    import busfetch_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [W-1:0] ir,
    input  logic [W-1:0] mdr,
    output ctl_state_t state,
    output ctl_word_t  cw
);

    ctl_state_t nxt;

    // Next state; decode reads the opcode of the word moving into IR.
    always_comb begin
        unique case (state)
            ST_FETCH_A: nxt = ST_FETCH_B;
            ST_FETCH_B: nxt = ST_FETCH_C;
            ST_FETCH_C: nxt = (mdr[W-1:W-4] == OP_NOT) ? ST_EXEC_NOT : ST_FETCH_A;
            default:    nxt = ST_FETCH_A;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_FETCH_A;
        else        state <= nxt;
    end

    // Control word for the current state.
    always_comb begin
        cw = '0;
        cw.pc_sel = PCSEL_HOLD;
        cw.alu_fn = ALU_PASS;
        cw.dst    = ir[11:9];
        cw.src1   = ir[8:6];
        unique case (state)
            ST_FETCH_A: begin
                cw.gate_pc = 1'b1;
                cw.ld_mar  = 1'b1;
            end
            ST_FETCH_B: begin
                cw.mem_en       = 1'b1;
                cw.ld_mdr       = 1'b1;
                cw.mdr_from_mem = 1'b1;
                cw.ld_pc        = 1'b1;
                cw.pc_sel       = PCSEL_INC;
            end
            ST_FETCH_C: begin
                cw.gate_mdr = 1'b1;
                cw.ld_ir    = 1'b1;
            end
            default: begin
                cw.gate_alu = 1'b1;
                cw.alu_fn   = ALU_NOT;
                cw.ld_reg   = 1'b1;
                cw.ld_cc    = 1'b1;
            end
        endcase
    end

    a_r2_single_gate: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cw.gate_pc, cw.gate_mdr, cw.gate_alu}));

    a_r4_fetch_b_set: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FETCH_B) |-> (cw.mem_en && cw.ld_mdr && cw.mdr_from_mem &&
                                   cw.ld_pc && cw.pc_sel == PCSEL_INC));

    a_r6_order: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FETCH_A) |=> (state == ST_FETCH_B));

    a_r9_cc_subset: assert property (@(posedge clk) disable iff (!rst_n)
        cw.ld_cc |-> op_sets_cc(ir[W-1:W-4]));

endmodule

// File: rtl/busfetch_core.sv
// Top: PC, MAR, MDR, IR, condition codes and the shared bus, wired to the
// register file, ALU, memory and control unit. The bus is a gated mux;
// each register captures it only under its load enable.
// Assumes memory is loaded under reset and the program stays in range.
module busfetch_core
    import busfetch_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_we,
    input  logic [ADDR_W-1:0] prog_addr,
    input  logic [15:0]       prog_data,
    input  logic [2:0]        rd_sel,
    output logic [15:0]       rd_data,
    output logic [15:0]       pc_q,
    output logic [15:0]       ir_q,
    output logic [2:0]        cc_q,
    output logic [2:0]        drv_q,
    output logic              fetch_start
);

    localparam int W = WORD_W;

    ctl_state_t     state;
    ctl_word_t      cw;
    logic [W-1:0]   pc, mar, mdr, ir;
    logic [W-1:0]   bus;
    logic [W-1:0]   alu_out, src_a, src_b, mem_rd;
    logic [2:0]     nzp;

    bf_ctrl #(.W(W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .ir(ir), .mdr(mdr), .state(state), .cw(cw)
    );

    bf_regfile #(.N(REG_N), .W(W)) u_rf (
        .clk(clk), .rst_n(rst_n),
        .we(cw.ld_reg), .waddr(cw.dst), .wdata(bus),
        .raddr_a(cw.src1), .raddr_b(ir[2:0]), .raddr_o(rd_sel),
        .rdata_a(src_a), .rdata_b(src_b), .rdata_o(rd_data)
    );

    bf_alu #(.W(W), .IMM_W(5)) u_alu (
        .fn(cw.alu_fn), .ir(ir), .op_a(src_a), .op_b_reg(src_b), .result(alu_out)
    );

    bf_mem #(.AW(ADDR_W), .W(W)) u_mem (
        .clk(clk), .rst_n(rst_n),
        .load_we(prog_we), .load_addr(prog_addr), .load_data(prog_data),
        .en(cw.mem_en), .addr(mar[ADDR_W-1:0]), .rdata(mem_rd)
    );

    // Gated bus: the selected source, zero when nothing drives.
    always_comb begin
        bus = '0;
        if (cw.gate_pc)       bus = pc;
        else if (cw.gate_mdr) bus = mdr;
        else if (cw.gate_alu) bus = alu_out;
    end

    // Program counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc <= PC_RESET;
        end else if (cw.ld_pc) begin
            unique case (cw.pc_sel)
                PCSEL_INC: pc <= pc + 16'd1;
                PCSEL_BUS: pc <= bus;
                default:   pc <= pc;
            endcase
        end
    end

    // Memory address register, loaded from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n)         mar <= '0;
        else if (cw.ld_mar) mar <= bus;
    end

    // Memory data register, from memory or bus.
    always_ff @(posedge clk) begin
        if (!rst_n)         mdr <= '0;
        else if (cw.ld_mdr) mdr <= cw.mdr_from_mem ? mem_rd : bus;
    end

    // Instruction register, loaded from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n)        ir <= '0;
        else if (cw.ld_ir) ir <= bus;
    end

    // Condition codes from the sign of the bus value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nzp <= 3'b010;
        end else if (cw.ld_cc) begin
            nzp <= {bus[W-1], bus == '0, !bus[W-1] && bus != '0};
        end
    end

    // Port outputs.
    always_comb begin
        pc_q        = pc;
        ir_q        = ir;
        cc_q        = nzp;
        drv_q       = {cw.gate_pc, cw.gate_mdr, cw.gate_alu};
        fetch_start = (state == ST_FETCH_A);
    end

    a_r3_mar_gets_pc: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FETCH_A) |=> (mar == $past(pc)));

    a_r4_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FETCH_B) |=> (pc == $past(pc) + 16'd1));

    a_r5_ir_from_mdr: assert property (@(posedge clk) disable iff (!rst_n)
        cw.ld_ir |=> (ir == $past(mdr)));

    a_r8_cc_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(nzp));

    a_r9_cc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cw.ld_cc |=> $stable(nzp));

endmodule

// File: tb/sim_busfetch_core.sv
// Bench: loads a program of complement and non-complement instructions,
// then walks it cycle by cycle checking gates, PC, IR, codes and registers
// against a model computed from the requirements.
module sim_busfetch_core;

    localparam int CLK_PERIOD = 20;
    localparam int NPROG      = 96;
    localparam int WATCHDOG   = 5000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        prog_we = 1'b0;
    logic [7:0]  prog_addr = '0;
    logic [15:0] prog_data = '0;
    logic [2:0]  rd_sel = '0;
    logic [15:0] rd_data, pc_q, ir_q;
    logic [2:0]  cc_q, drv_q;
    logic        fetch_start;

    int checks = 0;
    int fails  = 0;
    logic [15:0] prog [NPROG];
    logic [15:0] mreg [8];
    logic [2:0]  mcc;

    always #(CLK_PERIOD/2) clk = ~clk;

    busfetch_core #(.ADDR_W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .prog_we(prog_we), .prog_addr(prog_addr),
        .prog_data(prog_data), .rd_sel(rd_sel), .rd_data(rd_data),
        .pc_q(pc_q), .ir_q(ir_q), .cc_q(cc_q), .drv_q(drv_q),
        .fetch_start(fetch_start)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] mk_not(input int d, input int s);
        return {4'b1001, 3'(d), 3'(s), 6'b111111};
    endfunction

    // Program: a few fixed complements reaching N, Z and P, then a mix.
    task automatic build_prog();
        prog[0] = mk_not(0, 0);
        prog[1] = mk_not(0, 0);
        prog[2] = mk_not(1, 1);
        prog[3] = mk_not(2, 1);
        for (int k = 4; k < NPROG; k++) begin
            if (k % 3 != 2) begin
                prog[k] = mk_not((k * 5) % 8, (k % 4 == 0) ? (k * 5) % 8 : (k * 3) % 8);
            end else begin
                logic [3:0] op;
                op = 4'((k * 7) % 16);
                if (op == 4'b1001) op = 4'b0001;
                prog[k] = {op, 12'((k * 16'h13) ^ 16'h0a5)};
            end
        end
    endtask

    task automatic check_regs(input string req);
        for (int r = 0; r < 8; r++) begin
            rd_sel = 3'(r);
            #1;
            chk(req, rd_data, mreg[r]);
        end
    endtask

    // R1: reset values; R3-R9 per instruction.
    initial begin
        build_prog();
        for (int r = 0; r < 8; r++) mreg[r] = 16'(r * 16'h1111);
        mcc = 3'b010;
        for (int a = 0; a < NPROG; a++) begin
            @(negedge clk);
            prog_we = 1'b1;
            prog_addr = 8'(a);
            prog_data = prog[a];
        end
        @(negedge clk);
        prog_we = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 pc", pc_q, 16'h3000);
        chk("R1 ir", ir_q, 16'h0000);
        chk("R1 cc", 16'(cc_q), 16'h0002);
        chk("R1 fetch_start", 16'(fetch_start), 16'h0001);
        check_regs("R1 regs");
        for (int k = 0; k < NPROG; k++) begin
            logic is_not;
            // fetch cycle 1 (R3, R4 PC value, R6 boundary)
            chk("R3 drv", 16'(drv_q), 16'h0004);
            chk("R6 fetch_start", 16'(fetch_start), 16'h0001);
            chk("R4 pc per fetch", pc_q, 16'(16'h3000 + k));
            if (k > 0) begin
                chk("R5 ir holds", ir_q, prog[k-1]);
                chk("R8/R9 cc", 16'(cc_q), 16'(mcc));
                check_regs("R7/R9 regs");
            end
            @(negedge clk); #1;
            chk("R4 drv", 16'(drv_q), 16'h0000);
            chk("R2 drivers", 16'($countones(drv_q) <= 1), 16'h0001);
            @(negedge clk); #1;
            chk("R5 drv", 16'(drv_q), 16'h0002);
            chk("R4 pc inc", pc_q, 16'(16'h3001 + k));
            is_not = (prog[k][15:12] == 4'b1001);
            if (is_not) begin
                @(negedge clk); #1;
                chk("R7 drv", 16'(drv_q), 16'h0001);
                chk("R6 exec", 16'(fetch_start), 16'h0000);
                chk("R5 ir", ir_q, prog[k]);
                begin
                    logic [15:0] res;
                    res = ~mreg[prog[k][8:6]];
                    mreg[prog[k][11:9]] = res;
                    mcc = {res[15], res == 16'h0, !res[15] && res != 16'h0};
                end
            end
            @(negedge clk); #1;
        end
        chk("R6 final fetch", 16'(fetch_start), 16'h0001);
        chk("R8 final cc", 16'(cc_q), 16'(mcc));
        check_regs("R7 final regs");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule